// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block converts single writes from a simple register-style write port into the command and address cycles of an 8-bit NAND flash device. Two bits of the write address choose what kind of cycle goes out. One bit raises the command latch enable and the other raises the address latch enable. The write data is driven onto the flash data bus for the length of the cycle. Each cycle has three phases: a setup phase, a phase with write enable low, and a hold phase. The length of each phase comes from a set of timing inputs.

A third, higher address bit marks a special window. An address write that lands in this window takes its setup, write-enable-low and hold counts from a second set of timing inputs. The hold count is chosen to cover the time the flash needs to pull its ready/busy line low. When the hold phase ends, the block keeps the write unacknowledged and watches the ready/busy input. It releases the bus only once the flash reports ready. A typical use is the last address byte of an erase or program sequence, so that the host is not released before the device has finished.

Top module: `nand_cmd_seq`

## Requirements
- R1: While reset is held and after it is released: chip enable and write enable are high, read enable is high, both latch enables are low, the data output enable is low, and wr_ready is high.
- R2: A write is taken on a rising clock edge at which wr_valid and wr_ready are both high. From the next cycle, wr_ready stays low until the transaction ends. It returns high in the first idle cycle.
- R3: Address bit 16 of the write drives the command latch enable and address bit 17 drives the address latch enable. The write data appears on the data output. All three stay constant through the setup, write-enable-low and hold phases of the cycle.
- R4: With common timing, setup lasts cfg_setup cycles, write enable is low for cfg_we_low cycles, and hold lasts cfg_hold cycles. A count of zero acts as one cycle.
- R5: A write with both address bit 27 and address bit 17 set uses the special counts. Its setup and write-enable-low phases take spc_setup and spc_we_low cycles, with zero acting as one. Its hold phase lasts spc_hold+1 cycles. A write with bit 27 set but bit 17 clear uses common timing.
- R6: After the hold phase of a special write, wr_ready stays low and chip enable stays low for as long as the ready/busy input is sampled low. The block goes idle on the cycle after ready/busy is sampled high. A common write ignores ready/busy.
- R7: Chip enable is low in every cycle of a transaction, including setup, hold and the ready wait. It is high in every idle cycle.
- R8: Read enable never goes low. The data output enable is high only during the setup, write-enable-low and hold phases. It is low while idle and during the ready wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid; low while busy |
| wr_addr | input | AW (28) | Write address; bits 16, 17 and 27 select the cycle type |
| wr_data | input | DW (8) | Command or address byte |
| cfg_setup | input | CW (4) | Common setup count |
| cfg_we_low | input | CW (4) | Common write-enable-low count |
| cfg_hold | input | CW (4) | Common hold count |
| spc_setup | input | CW (4) | Special setup count |
| spc_we_low | input | CW (4) | Special write-enable-low count |
| spc_hold | input | CW (4) | Special hold count; the hold lasts this value plus one |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy (synchronous to clk) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low (held high) |
| nand_dq_out | output | DW (8) | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |

## Verification
Directed writes cover a command, a plain address, an address in the special window, and a command in the special window. Together they separate the three latch-enable choices and show whether the special timing is applied only when it should be. Zero timing counts and a special hold of zero probe the clamp and the plus-one hold. Special writes with a busy period of zero cycles and of several cycles show that the ready wait has a minimum length and also extends as long as the device stays busy. In the random writes, ready/busy toggles during common writes, which exposes any wrongful wait. Every cycle of every write is compared pin by pin with a phase model in the bench.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WEL   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_WAIT  = 3'd4
  } seq_state_t;

  function automatic logic phase_drives(input seq_state_t s);
    return (s == ST_SETUP) || (s == ST_WEL) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/nand_addr_decode.sv
module nand_addr_decode #(
  parameter int AW      = 28,
  parameter int CLE_BIT = 16,
  parameter int ALE_BIT = 17,
  parameter int SP_BIT  = 27
) (
  input  logic [AW-1:0] addr,
  output logic          is_cmd,
  output logic          is_addr,
  output logic          is_special
);

  always_comb begin
    is_cmd     = addr[CLE_BIT];
    is_addr    = addr[ALE_BIT];
    // the special window applies to address cycles only
    is_special = addr[SP_BIT] & addr[ALE_BIT];
  end

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ONE;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (cnt > ONE) begin
      cnt <= cnt - ONE;
    end
  end

  assign done = (cnt == ONE);

  a_r4_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_t    st_nxt,
  input  logic          accept,
  input  logic          in_cle,
  input  logic          in_ale,
  input  logic [DW-1:0] in_data,
  output logic          wr_ready,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  logic          cap_cle, cap_ale;
  logic [DW-1:0] cap_data;
  logic          f_cle, f_ale;
  logic [DW-1:0] f_data;
  logic          drive;

  always_comb begin
    f_cle  = accept ? in_cle  : cap_cle;
    f_ale  = accept ? in_ale  : cap_ale;
    f_data = accept ? in_data : cap_data;
    drive  = phase_drives(st_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_cle  <= 1'b0;
      cap_ale  <= 1'b0;
      cap_data <= '0;
      wr_ready <= 1'b1;
      ce_n     <= 1'b1;
      cle      <= 1'b0;
      ale      <= 1'b0;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
    end else begin
      cap_cle  <= f_cle;
      cap_ale  <= f_ale;
      cap_data <= f_data;
      wr_ready <= (st_nxt == ST_IDLE);
      ce_n     <= (st_nxt == ST_IDLE);
      cle      <= drive & f_cle;
      ale      <= drive & f_ale;
      we_n     <= (st_nxt != ST_WEL);
      re_n     <= 1'b1;
      dq_out   <= f_data;
      dq_oe    <= drive;
    end
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int AW      = 28,
  parameter int DW      = 8,
  parameter int CW      = 4,
  parameter int CLE_BIT = 16,
  parameter int ALE_BIT = 17,
  parameter int SP_BIT  = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_we_low,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] spc_setup,
  input  logic [CW-1:0] spc_we_low,
  input  logic [CW-1:0] spc_hold,
  input  logic          nand_rb_n,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] nand_dq_out,
  output logic          nand_dq_oe
);

  localparam int TW = CW + 1;

  seq_state_t    st, st_nxt;
  logic          dec_cmd, dec_addr, dec_sp;
  logic          is_sp;
  logic          accept;
  logic          t_load, t_done;
  logic [TW-1:0] t_val;

  nand_addr_decode #(
    .AW(AW), .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT), .SP_BIT(SP_BIT)
  ) u_dec (
    .addr(wr_addr), .is_cmd(dec_cmd), .is_addr(dec_addr), .is_special(dec_sp)
  );

  nand_phase_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  assign accept = wr_valid && wr_ready && (st == ST_IDLE);

  always_comb begin
    st_nxt = st;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st)
      ST_IDLE: if (accept) begin
        st_nxt = ST_SETUP;
        t_load = 1'b1;
        t_val  = TW'(dec_sp ? spc_setup : cfg_setup);
      end
      ST_SETUP: if (t_done) begin
        st_nxt = ST_WEL;
        t_load = 1'b1;
        t_val  = TW'(is_sp ? spc_we_low : cfg_we_low);
      end
      ST_WEL: if (t_done) begin
        st_nxt = ST_HOLD;
        t_load = 1'b1;
        t_val  = is_sp ? (TW'(spc_hold) + TW'(1)) : TW'(cfg_hold);
      end
      ST_HOLD: if (t_done) begin
        st_nxt = is_sp ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: if (nand_rb_n) begin
        st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      is_sp <= 1'b0;
    end else begin
      st <= st_nxt;
      if (accept) is_sp <= dec_sp;
    end
  end

  nand_pin_drive #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .accept(accept),
    .in_cle(dec_cmd), .in_ale(dec_addr), .in_data(wr_data),
    .wr_ready(wr_ready), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe)
  );

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  a_r6_busy_holds_wait: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !nand_rb_n) |=> (st == ST_WAIT && !wr_ready && !nand_ce_n));

  a_r5_common_skips_wait: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !is_sp && t_done) |=> (st == ST_IDLE));

  a_r7_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> (!nand_ce_n && nand_dq_oe));

  a_r3_fields_stable: assert property (@(posedge clk) disable iff (rst)
    (!nand_ce_n && !$past(nand_ce_n) && nand_dq_oe && $past(nand_dq_oe))
      |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dq_out)));

endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_valid;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] cfg_setup, cfg_we_low, cfg_hold;
  logic [CW-1:0] spc_setup, spc_we_low, spc_hold;
  logic          nand_rb_n;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [DW-1:0] nand_dq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_seq dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_setup(cfg_setup), .cfg_we_low(cfg_we_low), .cfg_hold(cfg_hold),
    .spc_setup(spc_setup), .spc_we_low(spc_we_low), .spc_hold(spc_hold),
    .nand_rb_n(nand_rb_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp1(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // phase codes of the bench model: 0 idle, 1 setup, 2 we low, 3 hold, 4 wait
  function automatic int model_phase(input int k, input int s, input int w,
                                     input int h, input bit sp, input int busy);
    if (k < s) return 1;
    if (k < s + w) return 2;
    if (k < s + w + h) return 3;
    if (sp && k <= s + w + h + busy) return 4;
    return 0;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int busy);
    bit sp, c, l;
    int s, w, h, total, ph;
    c  = a[16];
    l  = a[17];
    sp = a[27] && a[17];
    s  = sp ? clamp1(spc_setup)  : clamp1(cfg_setup);
    w  = sp ? clamp1(spc_we_low) : clamp1(cfg_we_low);
    h  = sp ? int'(spc_hold) + 1 : clamp1(cfg_hold);
    total = s + w + h + (sp ? busy + 1 : 0);
    @(negedge clk);
    chk("R2", "ready before request", {31'd0, wr_ready}, 32'd1);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    nand_rb_n = sp ? (busy == 0) : 1'($urandom);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int k = 0; k <= total; k++) begin
      if (sp) nand_rb_n = (k >= s + w + h + busy);
      else    nand_rb_n = 1'($urandom);
      ph = model_phase(k, s, w, h, sp, busy);
      chk("R7", "ce_n", {31'd0, nand_ce_n}, {31'd0, ph == 0});
      chk("R3", "cle", {31'd0, nand_cle}, {31'd0, (ph >= 1 && ph <= 3) && c});
      chk("R3", "ale", {31'd0, nand_ale}, {31'd0, (ph >= 1 && ph <= 3) && l});
      chk(sp ? "R5" : "R4", "we_n", {31'd0, nand_we_n}, {31'd0, ph != 2});
      chk("R8", "re_n", {31'd0, nand_re_n}, 32'd1);
      chk("R8", "dq_oe", {31'd0, nand_dq_oe}, {31'd0, ph >= 1 && ph <= 3});
      if (ph >= 1 && ph <= 3) chk("R3", "dq_out", {24'd0, nand_dq_out}, {24'd0, d});
      chk(ph == 4 ? "R6" : "R2", "wr_ready", {31'd0, wr_ready}, {31'd0, ph == 0});
      @(negedge clk);
    end
    nand_rb_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; nand_rb_n = 1'b1;
    cfg_setup = 4'd1; cfg_we_low = 4'd1; cfg_hold = 4'd1;
    spc_setup = 4'd2; spc_we_low = 4'd3; spc_hold = 4'd4;
    repeat (3) @(negedge clk);
    chk("R1", "ce_n in reset", {31'd0, nand_ce_n}, 32'd1);
    chk("R1", "we_n in reset", {31'd0, nand_we_n}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ce_n", {31'd0, nand_ce_n}, 32'd1);
    chk("R1", "we_n", {31'd0, nand_we_n}, 32'd1);
    chk("R1", "re_n", {31'd0, nand_re_n}, 32'd1);
    chk("R1", "cle", {31'd0, nand_cle}, 32'd0);
    chk("R1", "ale", {31'd0, nand_ale}, 32'd0);
    chk("R1", "dq_oe", {31'd0, nand_dq_oe}, 32'd0);
    chk("R1", "wr_ready", {31'd0, wr_ready}, 32'd1);

    // directed: command, plain address, special address, command in special window
    do_write(28'h001_0000, 8'h70, 0);
    do_write(28'h002_0000, 8'h11, 0);
    do_write(28'h802_0000, 8'h22, 3);
    do_write(28'h801_0000, 8'h33, 0);
    // zero counts clamp to one; special hold of zero lasts one cycle
    cfg_setup = 4'd0; cfg_we_low = 4'd0; cfg_hold = 4'd0;
    spc_setup = 4'd0; spc_we_low = 4'd0; spc_hold = 4'd0;
    do_write(28'h002_0abc, 8'h44, 0);
    do_write(28'h802_0001, 8'h55, 0);
    do_write(28'h802_0002, 8'h66, 7);
    // largest counts
    cfg_setup = 4'hf; cfg_we_low = 4'hf; cfg_hold = 4'hf; spc_hold = 4'hf;
    do_write(28'h001_0000, 8'haa, 0);
    do_write(28'h802_0000, 8'hbb, 2);

    for (int n = 0; n < 50; n++) begin
      logic [AW-1:0] a;
      cfg_setup  = 4'($urandom); cfg_we_low = 4'($urandom); cfg_hold = 4'($urandom);
      spc_setup  = 4'($urandom); spc_we_low = 4'($urandom); spc_hold = 4'($urandom);
      a = AW'($urandom);
      a[16] = 1'($urandom); a[17] = 1'($urandom); a[27] = 1'($urandom);
      do_write(a, 8'($urandom), int'($urandom_range(0, 5)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule